// File: doc/BRIEF.md
# Periodic interrupt pulse generator

This block turns the carry events of a time-of-day counter into a request for a processor. It drives an output-enable that pulls an open-drain pin low, and it keeps a readable request flag. A 2-bit rate field picks which event starts a request: the 1/64 s tick, the seconds carry, the minutes carry or the hours carry.

A mode bit picks one of two behaviours. In latched interrupt mode the pin stays low until software clears the flag. In standard-pulse mode the pin goes low for one 128 Hz period (7.8125 ms) and then releases by itself. A mask bit stops any request from starting and releases a request that is already active.

Events arrive as single-cycle pulses that line up with a 128 Hz tick pulse. Software acts through two strobes: one clears the flag and one marks a read of the flag. Bus decoding and the counters are outside this block. When a 30-second adjust command causes a minutes carry, the counter signals it on a separate strobe. If that adjust also carries into the hour, the counter reports it on the normal hours carry.

Top module: `tick_irq_gen`

## Requirements
- R1: Rate field encoding: 2'b00 selects the 1/64 s tick, 2'b01 the seconds carry, 2'b10 the minutes carry and 2'b11 the hours carry. Only the selected event can start a request; the other event inputs have no effect.
- R2: Both outputs are 0 after reset. Only an accepted event sets the flag, and it always sets the flag together with the pin drive. The flag is never 1 while the pin is released.
- R3: In latched mode (mode bit = 1), the pin drive and the flag stay 1 until the clear strobe arrives. The read strobe, 128 Hz ticks and further events leave both outputs unchanged.
- R4: In standard-pulse mode (mode bit = 0), an accepted event sets the pin drive and the flag. The next 128 Hz tick after the event clears both.
- R5: In standard-pulse mode, a read strobe or a clear strobe during a pulse sets the flag to 0 on the next cycle. The pin drive stays 1 until the ending 128 Hz tick.
- R6: While the mask bit is 1, no event is accepted. On the cycle after the mask is seen, the pin drive and the flag are both 0.
- R7: With the rate field at 2'b10, the adjust-minute-carry strobe counts as an event, the same as the minutes carry.
- R8: An event in the same cycle as a release is accepted as a new request, and both outputs are 1 on the next cycle. A release here is the clear strobe in latched mode, or the ending 128 Hz tick in standard-pulse mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel_i | input | 2 | Event rate select (encoding in R1) |
| latch_mode_i | input | 1 | 1 = latched interrupt, 0 = standard pulse |
| mask_i | input | 1 | 1 = suppress and release requests |
| tick64_i | input | 1 | 1/64 s tick pulse |
| sec_carry_i | input | 1 | Seconds carry pulse |
| min_carry_i | input | 1 | Minutes carry pulse |
| adj_min_carry_i | input | 1 | Minutes carry caused by a 30-second adjust |
| hour_carry_i | input | 1 | Hours carry pulse |
| tick128_i | input | 1 | 128 Hz timing tick pulse |
| flag_clr_i | input | 1 | Software clear of the request flag |
| flag_rd_i | input | 1 | Software read of the request flag |
| pin_pull_o | output | 1 | 1 = pull the open-drain pin low |
| flag_o | output | 1 | Request flag |

## Verification
Both outputs come from registers. Each result is due exactly one clock after the edge that samples the stimulus. The driver applies each cycle's inputs on the falling edge and queues the output pair that this stimulus should produce. The monitor pops that item a quarter period after the next rising edge and compares it. In this way every check lands in the single cycle where the requirement puts the result. This covers the end of a standard pulse on the following 128 Hz tick and the release one cycle after the mask is raised.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int RATE_W = 2;
  localparam int NUM_RATES = 1 << RATE_W;

  typedef enum logic [RATE_W-1:0] {
    RATE_TICK64 = 2'b00,
    RATE_SEC    = 2'b01,
    RATE_MIN    = 2'b10,
    RATE_HOUR   = 2'b11
  } rate_e;
endpackage

// File: rtl/irq_event_sel.sv
module irq_event_sel
  import irq_pkg::*;
(
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              tick64_i,
  input  logic              sec_carry_i,
  input  logic              min_carry_i,
  input  logic              adj_min_carry_i,
  input  logic              hour_carry_i,
  output logic              evt_o
);
  logic [NUM_RATES-1:0] src;

  always_comb begin
    src = '0;
    src[RATE_TICK64] = tick64_i;
    src[RATE_SEC]    = sec_carry_i;
    src[RATE_MIN]    = min_carry_i | adj_min_carry_i;
    src[RATE_HOUR]   = hour_carry_i;
  end

  assign evt_o = src[rate_sel_i];
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic latch_mode_i,
  input  logic mask_i,
  input  logic flag_clr_i,
  input  logic tick128_i,
  output logic accept_o,
  output logic release_o,
  output logic pull_q
);
  // the release condition frees the pin for a new request in the same cycle
  assign release_o = latch_mode_i ? flag_clr_i : tick128_i;
  assign accept_o  = evt_i & ~mask_i & (~pull_q | release_o);

  always_ff @(posedge clk) begin
    if (!rst_n) pull_q <= 1'b0;
    else        pull_q <= ~mask_i & (accept_o | (pull_q & ~release_o));
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    latch_mode_i && pull_q && !flag_clr_i && !mask_i |=> pull_q); // R3
  AST_STD_END: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_mode_i && pull_q && tick128_i && !evt_i |=> !pull_q); // R4
  AST_MASK_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    mask_i |=> !pull_q); // R6
  AST_RISE_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> $past(evt_i)); // R2
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic release_i,
  input  logic latch_mode_i,
  input  logic mask_i,
  input  logic flag_rd_i,
  input  logic flag_clr_i,
  output logic flag_q
);
  logic early_clr;

  // in pulse mode software may drop the flag before the pin releases
  assign early_clr = ~latch_mode_i & (flag_rd_i | flag_clr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= ~mask_i & (accept_i | (flag_q & ~release_i & ~early_clr));
  end

  AST_MASK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    mask_i |=> !flag_q); // R6
  AST_LATCH_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    latch_mode_i && flag_q && flag_rd_i && !flag_clr_i && !mask_i |=> flag_q); // R3
endmodule

// File: rtl/tick_irq_gen.sv
module tick_irq_gen
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              latch_mode_i,
  input  logic              mask_i,
  input  logic              tick64_i,
  input  logic              sec_carry_i,
  input  logic              min_carry_i,
  input  logic              adj_min_carry_i,
  input  logic              hour_carry_i,
  input  logic              tick128_i,
  input  logic              flag_clr_i,
  input  logic              flag_rd_i,
  output logic              pin_pull_o,
  output logic              flag_o
);
  logic evt, accept, rel, pull_q, flag_q;

  irq_event_sel u_sel (
    .rate_sel_i(rate_sel_i), .tick64_i(tick64_i), .sec_carry_i(sec_carry_i),
    .min_carry_i(min_carry_i), .adj_min_carry_i(adj_min_carry_i),
    .hour_carry_i(hour_carry_i), .evt_o(evt)
  );

  irq_pin_ctrl u_pin (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .latch_mode_i(latch_mode_i),
    .mask_i(mask_i), .flag_clr_i(flag_clr_i), .tick128_i(tick128_i),
    .accept_o(accept), .release_o(rel), .pull_q(pull_q)
  );

  irq_flag_reg u_flag (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .release_i(rel),
    .latch_mode_i(latch_mode_i), .mask_i(mask_i), .flag_rd_i(flag_rd_i),
    .flag_clr_i(flag_clr_i), .flag_q(flag_q)
  );

  assign pin_pull_o = pull_q;
  assign flag_o     = flag_q;

  AST_FLAG_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |-> pull_q); // R2
  AST_STD_EARLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_mode_i && pull_q && flag_rd_i && !tick128_i && !mask_i
    |=> pull_q && !flag_q); // R5
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    latch_mode_i && pull_q && flag_clr_i && (rate_sel_i == RATE_SEC) && sec_carry_i && !mask_i
    |=> pull_q && flag_q); // R8
endmodule

// File: tb/tick_irq_gen_tb.sv
module tick_irq_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rate_sel_i = 2'b00;
  logic latch_mode_i = 1'b1, mask_i = 1'b0;
  logic tick64_i = 0, sec_carry_i = 0, min_carry_i = 0, adj_min_carry_i = 0;
  logic hour_carry_i = 0, tick128_i = 0, flag_clr_i = 0, flag_rd_i = 0;
  logic pin_pull_o, flag_o;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic pull; logic flag; string tag; } exp_t;
  exp_t sb[$];

  // staged stimulus for the next cycle; strobes return to 0 after each step
  logic [1:0] st_rate = 2'b00;
  logic st_latch = 1, st_mask = 0;
  logic st_t64 = 0, st_sec = 0, st_min = 0, st_adj = 0, st_hr = 0;
  logic st_t128 = 0, st_clr = 0, st_rd = 0;

  always #10 clk = ~clk;

  tick_irq_gen u_dut (
    .clk(clk), .rst_n(rst_n), .rate_sel_i(rate_sel_i), .latch_mode_i(latch_mode_i),
    .mask_i(mask_i), .tick64_i(tick64_i), .sec_carry_i(sec_carry_i),
    .min_carry_i(min_carry_i), .adj_min_carry_i(adj_min_carry_i),
    .hour_carry_i(hour_carry_i), .tick128_i(tick128_i), .flag_clr_i(flag_clr_i),
    .flag_rd_i(flag_rd_i), .pin_pull_o(pin_pull_o), .flag_o(flag_o)
  );

  task automatic check(input logic ap, input logic af, input logic ep, input logic ef, input string tag);
    checks++;
    if (ap !== ep || af !== ef) begin
      errors++;
      $display("FAIL %s: pull/flag actual %b%b expected %b%b", tag, ap, af, ep, ef);
    end
  endtask

  task automatic step(input logic ep, input logic ef, input string tag);
    exp_t e;
    @(negedge clk);
    rate_sel_i = st_rate; latch_mode_i = st_latch; mask_i = st_mask;
    tick64_i = st_t64; sec_carry_i = st_sec; min_carry_i = st_min;
    adj_min_carry_i = st_adj; hour_carry_i = st_hr; tick128_i = st_t128;
    flag_clr_i = st_clr; flag_rd_i = st_rd;
    e.pull = ep; e.flag = ef; e.tag = tag;
    sb.push_back(e);
    st_t64 = 0; st_sec = 0; st_min = 0; st_adj = 0; st_hr = 0;
    st_t128 = 0; st_clr = 0; st_rd = 0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check(pin_pull_o, flag_o, e.pull, e.flag, e.tag);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(20 * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #5;
    check(pin_pull_o, flag_o, 1'b0, 1'b0, "R2 reset");
    @(negedge clk);
    rst_n = 1;

    // R1 rate selection, latched mode
    st_rate = 2'b01; st_latch = 1;
    st_t64 = 1;  step(0, 0, "R1 tick64 ignored at rate 01");
    st_sec = 1;  step(1, 1, "R1 seconds carry at rate 01");
    st_clr = 1;  step(0, 0, "R3 clear releases");
    st_rate = 2'b00; st_t64 = 1; step(1, 1, "R1 tick64 at rate 00");
    st_clr = 1;  step(0, 0, "R3 clear");
    st_rate = 2'b10; st_sec = 1; st_hr = 1; step(0, 0, "R1 sec/hour ignored at rate 10");
    st_min = 1;  step(1, 1, "R1 minutes carry at rate 10");
    st_clr = 1;  step(0, 0, "R3 clear");
    st_adj = 1;  step(1, 1, "R7 adjust carry at rate 10");
    st_clr = 1;  step(0, 0, "R3 clear");
    st_rate = 2'b11; st_min = 1; st_adj = 1; step(0, 0, "R1 minute ignored at rate 11");
    st_hr = 1;   step(1, 1, "R1 hours carry at rate 11");

    // R3 latched hold
    st_t128 = 1; step(1, 1, "R3 tick128 no effect");
    st_rd = 1;   step(1, 1, "R3 read no effect");
    st_hr = 1;   step(1, 1, "R3 event while set ignored");
    step(1, 1, "R3 idle hold");
    // R8 clear with coincident event
    st_clr = 1; st_hr = 1; step(1, 1, "R8 clear plus event rearms");
    st_clr = 1;  step(0, 0, "R3 clear");

    // R4 standard pulse
    st_latch = 0; st_rate = 2'b00;
    st_t64 = 1; st_t128 = 1; step(1, 1, "R4 pulse start");
    step(1, 1, "R4 pulse held");
    st_t128 = 1; step(0, 0, "R4 pulse end on tick");
    // R5 early read
    st_t64 = 1; st_t128 = 1; step(1, 1, "R4 pulse start");
    st_rd = 1;   step(1, 0, "R5 read drops flag, pin held");
    step(1, 0, "R5 pin still held");
    st_t128 = 1; step(0, 0, "R5 pin ends on tick");
    // R5 early clear
    st_t64 = 1; st_t128 = 1; step(1, 1, "R4 pulse start");
    st_clr = 1;  step(1, 0, "R5 clear drops flag, pin held");
    // R8 event on ending tick
    st_t64 = 1; st_t128 = 1; step(1, 1, "R8 event at end restarts");
    st_t128 = 1; step(0, 0, "R4 restarted pulse ends");

    // R6 mask
    st_mask = 1; st_t64 = 1; st_t128 = 1; step(0, 0, "R6 masked event");
    st_mask = 0; st_latch = 1; st_t64 = 1; step(1, 1, "R6 unmasked event");
    st_mask = 1; step(0, 0, "R6 mask releases active request");
    st_mask = 0; step(0, 0, "R6 stays released after unmask");

    repeat (3) @(posedge clk);
    #8;
    finish_run();
  end
endmodule